// File: doc/BRIEF.md
# Pipelined 33-bit Unsigned Squarer

This block squares an unsigned operand of up to 33 bits and returns the full 66-bit result three clock cycles later. It needs only three narrow multiplications instead of four. It does this by taking advantage of the symmetry of a square. The operand is cut into a 17-bit low slice and a high slice of at most 16 bits. The two equal cross products become a single product. That product uses the high slice doubled, and the doubling is a one-bit left shift applied before the multiplier. Because of that shift, the three partial terms land at weights 0, 17 and 34. A chain of fixed 17-bit shift-and-add steps then combines them.

A producer presents an operand with a valid strobe in any cycle, including every cycle back to back. The square appears with its own valid strobe after a fixed latency. There is no back-pressure. Operands narrower than 33 bits, such as 24-bit or 32-bit values, are zero-extended by the user. The output register keeps its last value while no new result is valid.

Top module: `sq33_pipe`

## Requirements
- R1: After reset is released, `out_vld` is 0 until a valid operand has travelled through the pipeline.
- R2: `out_vld` is 1 exactly three rising clock edges after an edge at which `in_vld` was sampled 1, and 0 in every other cycle.
- R3: When `out_vld` is 1, `out_sq` equals the full unsigned 66-bit square of the `in_x` value sampled with that strobe. As a consequence, bit 1 of a valid `out_sq` is always 0 and bit 0 equals bit 0 of that operand.
- R4: The all-ones operand 2^33-1 gives 2^66 - 2^34 + 1, with no truncation.
- R5: The operand 0 gives 0.
- R6: Each power of two 2^k, for k from 0 to 32, gives 2^(2k). This includes the operands on both sides of the split between bit 16 and bit 17.
- R7: Operands presented on consecutive cycles give one result per cycle, in the order the operands were presented.
- R8: While `in_vld` is 0, the value on `in_x` is ignored: `out_vld` stays 0 and `out_sq` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low. Asserted asynchronously and released synchronously inside the block |
| in_vld | input | 1 | Operand strobe |
| in_x | input | 33 | Unsigned operand (zero-extend narrower values) |
| out_vld | output | 1 | Result strobe |
| out_sq | output | 66 | Unsigned square of the operand |

## Verification
The bound checker watches four things on every cycle. It checks that the result strobe follows the operand strobe by exactly three edges. It compares each valid result with a square computed from a delayed copy of the operand. It checks that bit 1 of every square is zero. It checks that the output holds steady whenever no result is valid.

Some cases need specific operands to be driven, and only the bench's scenarios can supply them. These are the boundary operands: zero, all ones, and every power of two across the 17-bit split. They also include fully back-to-back streams, isolated strobes separated by bubbles, and garbage data driven with the strobe low.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Number of partial terms used by the folded squaring scheme
  localparam int SQ_TERMS   = 3;
  // Register stages from operand to result
  localparam int SQ_LATENCY = 3;

  // Partial term slots, ordered by weight (index t has weight t*LO_W)
  typedef enum int {
    TERM_LOW  = 0,  // lo * lo
    TERM_MID  = 1,  // (2*hi) * lo
    TERM_HIGH = 2   // hi * hi
  } term_e;
endpackage

// File: rtl/sq_split.sv
// Splits the operand into a low slice, the high slice and the doubled high slice.
module sq_split #(
  parameter int IN_W = 33,
  parameter int LO_W = 17
) (
  input  logic [IN_W-1:0] x,
  output logic [LO_W-1:0] lo,
  output logic [LO_W-1:0] hi,
  output logic [LO_W-1:0] hi_dbl
);
  logic [IN_W-1:0] x_shr;

  assign x_shr  = x >> LO_W;
  assign lo     = x[LO_W-1:0];
  assign hi     = x_shr[LO_W-1:0];
  // Headroom of one bit: the high slice is narrower than LO_W
  assign hi_dbl = hi << 1;
endmodule

// File: rtl/sq_mul.sv
// One registered LO_W x LO_W unsigned product with a clock enable.
module sq_mul #(
  parameter int LO_W = 17,
  localparam int PRD_W = 2 * LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LO_W-1:0]  a,
  input  logic [LO_W-1:0]  b,
  output logic [PRD_W-1:0] p
);
  logic [PRD_W-1:0] p_d;

  always_comb begin
    p_d = PRD_W'(a) * PRD_W'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p <= '0;
    end else if (en) begin
      p <= p_d;
    end
  end
endmodule

// File: rtl/sq_acc.sv
// Combines weighted partial terms with a chain of fixed LO_W shift-and-add steps.
module sq_acc #(
  parameter int NTERM = 3,
  parameter int LO_W  = 17,
  parameter int OUT_W = 66,
  localparam int PRD_W = 2 * LO_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [NTERM*PRD_W-1:0] p_flat,
  output logic [OUT_W-1:0]       sum
);
  logic [OUT_W-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int t = NTERM - 1; t >= 0; t--) begin
      sum_d = (sum_d << LO_W) + OUT_W'(p_flat[t*PRD_W +: PRD_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
    end else if (en) begin
      sum <= sum_d;
    end
  end
endmodule

// File: rtl/sq33_pipe.sv
// Three-stage unsigned squarer: split/register, three products, weighted sum.
module sq33_pipe #(
  parameter int IN_W = 33,
  parameter int LO_W = 17,
  localparam int HI_W  = IN_W - LO_W,
  localparam int PRD_W = 2 * LO_W,
  localparam int OUT_W = 2 * IN_W,
  localparam int NTERM = sq_pkg::SQ_TERMS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_x,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_sq
);
  import sq_pkg::*;

  if (HI_W + 1 > LO_W || HI_W < 1) begin : g_bad_split
    $error("sq33_pipe: doubled high slice must fit in the low slice width");
  end

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  // Stage 1: operand split and operand registers
  logic [LO_W-1:0] lo, hi, hi_dbl;
  logic [LO_W-1:0] op_a_d [NTERM];
  logic [LO_W-1:0] op_b_d [NTERM];
  logic [LO_W-1:0] op_a_q [NTERM];
  logic [LO_W-1:0] op_b_q [NTERM];

  sq_split #(.IN_W(IN_W), .LO_W(LO_W)) u_split (
    .x      (in_x),
    .lo     (lo),
    .hi     (hi),
    .hi_dbl (hi_dbl)
  );

  always_comb begin
    op_a_d[TERM_LOW]  = lo;
    op_b_d[TERM_LOW]  = lo;
    op_a_d[TERM_MID]  = hi_dbl;
    op_b_d[TERM_MID]  = lo;
    op_a_d[TERM_HIGH] = hi;
    op_b_d[TERM_HIGH] = hi;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int t = 0; t < NTERM; t++) begin
        op_a_q[t] <= '0;
        op_b_q[t] <= '0;
      end
    end else if (in_vld) begin
      for (int t = 0; t < NTERM; t++) begin
        op_a_q[t] <= op_a_d[t];
        op_b_q[t] <= op_b_d[t];
      end
    end
  end

  // Valid pipeline
  logic v1_q, v2_q, v3_q;
  logic v1_d, v2_d, v3_d;

  always_comb begin
    v1_d = in_vld;
    v2_d = v1_q;
    v3_d = v2_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  // Stage 2: products
  logic [NTERM*PRD_W-1:0] prod_flat;

  for (genvar t = 0; t < NTERM; t++) begin : g_mul
    sq_mul #(.LO_W(LO_W)) u_mul (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (v1_q),
      .a     (op_a_q[t]),
      .b     (op_b_q[t]),
      .p     (prod_flat[t*PRD_W +: PRD_W])
    );
  end

  // Stage 3: weighted sum
  sq_acc #(.NTERM(NTERM), .LO_W(LO_W), .OUT_W(OUT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (v2_q),
    .p_flat (prod_flat),
    .sum    (out_sq)
  );

  assign out_vld = v3_q;
endmodule

// File: rtl/sq33_pipe_chk.sv
// Cycle-by-cycle checker bound to the squarer.
module sq33_pipe_chk #(
  parameter int IN_W  = 33,
  parameter int OUT_W = 66
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_x,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_sq
);
  logic [1:0]      cyc;
  logic [IN_W-1:0] x_d1, x_d2, x_d3;
  logic            v_d1, v_d2, v_d3;
  logic [OUT_W-1:0] model;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      x_d1 <= '0;
      x_d2 <= '0;
      x_d3 <= '0;
      v_d1 <= 1'b0;
      v_d2 <= 1'b0;
      v_d3 <= 1'b0;
    end else begin
      if (cyc != 2'd3) begin
        cyc <= cyc + 2'd1;
      end
      x_d1 <= in_x;
      x_d2 <= x_d1;
      x_d3 <= x_d2;
      v_d1 <= in_vld;
      v_d2 <= v_d1;
      v_d3 <= v_d2;
    end
  end

  assign model = OUT_W'(x_d3) * OUT_W'(x_d3);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> !out_vld);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_vld == v_d3));

  // R3
  square_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_vld) |-> (out_sq == model));

  // R3
  square_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_sq[1] == 1'b0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !out_vld) |-> $stable(out_sq));
endmodule

bind sq33_pipe sq33_pipe_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .in_vld  (in_vld),
  .in_x    (in_x),
  .out_vld (out_vld),
  .out_sq  (out_sq)
);

// File: tb/sq33_pipe_bench.sv
module sq33_pipe_bench;
  localparam int IN_W  = 33;
  localparam int OUT_W = 66;

  logic             clk;
  logic             rst_n;
  logic             in_vld;
  logic [IN_W-1:0]  in_x;
  logic             out_vld;
  logic [OUT_W-1:0] out_sq;

  int n_chk;
  int n_fail;
  int cyc_cnt;
  bit done;

  logic [IN_W-1:0] stim [64];

  sq33_pipe u_sq33_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_x    (in_x),
    .out_vld (out_vld),
    .out_sq  (out_sq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [OUT_W-1:0] sq_ref(input logic [IN_W-1:0] v);
    return OUT_W'(v) * OUT_W'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [OUT_W-1:0] act,
                     input logic [OUT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive stim[0..n-1] on consecutive cycles and check each result three cycles later
  task automatic run_stream(input int n, input string tag);
    for (int t = 0; t < n + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        chk(out_vld == 1'b1, {tag, " valid"}, OUT_W'(out_vld), 1);
        chk(out_sq == sq_ref(stim[t-3]), {tag, " value"}, out_sq, sq_ref(stim[t-3]));
      end
      if (t < n) begin
        in_vld = 1'b1;
        in_x   = stim[t];
      end else begin
        in_vld = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_vld == 1'b0, {tag, " valid drops"}, OUT_W'(out_vld), 0);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_x   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: no result strobe and cleared output after reset
    chk(out_vld == 1'b0, "R1 out_vld after reset", OUT_W'(out_vld), 0);
    chk(out_sq == '0, "R1 out_sq after reset", out_sq, 0);
  endtask

  task automatic t_zero();
    stim[0] = '0;
    run_stream(1, "R5 zero");
  endtask

  task automatic t_ones();
    stim[0] = '1;
    run_stream(1, "R4 all-ones");
    chk(out_sq == {{(OUT_W-IN_W-1){1'b1}}, {IN_W{1'b0}}, 1'b1} - {1'b1, {(OUT_W-1){1'b0}}}
        + {1'b1, {(OUT_W-1){1'b0}}},
        "R4 closed form", out_sq, sq_ref('1));
  endtask

  task automatic t_pow2();
    for (int k = 0; k < IN_W; k++) begin
      stim[k] = IN_W'(1) << k;
    end
    // R6 and R7: back-to-back powers of two across the 17-bit split
    run_stream(IN_W, "R6 R7 powers of two");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      stim[i] = IN_W'({$urandom, $urandom});
    end
    run_stream(40, "R3 R7 random stream");
    for (int i = 0; i < 20; i++) begin
      stim[i] = (i % 2 == 0) ? IN_W'($urandom & 32'h00FF_FFFF) : IN_W'($urandom);
    end
    stim[20] = IN_W'(32'h00FF_FFFF);
    stim[21] = IN_W'(32'hFFFF_FFFF);
    stim[22] = IN_W'(17'h1FFFF);
    stim[23] = IN_W'(18'h20000);
    run_stream(24, "R3 24/32-bit operands");
  endtask

  // R2: isolated strobe, result exactly three edges later and one cycle wide
  task automatic t_latency();
    logic [IN_W-1:0] v;
    v = IN_W'(33'h1_2345_6789);
    @(negedge clk);
    in_vld = 1'b1;
    in_x   = v;
    for (int t = 1; t <= 4; t++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_x   = IN_W'($urandom);
      if (t == 3) begin
        chk(out_vld == 1'b1, "R2 strobe at edge 3", OUT_W'(out_vld), 1);
        chk(out_sq == sq_ref(v), "R2 value at edge 3", out_sq, sq_ref(v));
      end else begin
        chk(out_vld == 1'b0, "R2 no strobe off edge 3", OUT_W'(out_vld), 0);
      end
    end
  endtask

  // R8: data with strobe low is ignored, output holds
  task automatic t_hold();
    logic [OUT_W-1:0] last;
    stim[0] = IN_W'(33'h0_ABCD_1234);
    run_stream(1, "R8 setup");
    last = sq_ref(stim[0]);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_x   = IN_W'({$urandom, $urandom});
      chk(out_vld == 1'b0, "R8 strobe stays low", OUT_W'(out_vld), 0);
      chk(out_sq == last, "R8 output holds", out_sq, last);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    cyc_cnt = 0;
    done    = 1'b0;
    t_reset();
    t_zero();
    t_ones();
    t_pow2();
    t_random();
    t_latency();
    t_hold();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule